// File: doc/BRIEF.md
# CAN Window-Mailbox Transmit and Receive Frame Queues

This block holds the register-side message queues of a CAN controller: one four-deep transmit queue and one four-deep receive queue. The CPU never addresses a queue slot directly. It writes an outgoing frame into a fixed transmit window, then writes 0xFF to a transmit advance register to commit the frame. It reads an incoming frame from a fixed receive window, then writes 0xFF to a receive advance register to drop that frame and show the next one.

The protocol engine sees the other end of each queue. It takes the oldest committed transmit frame from a valid/done pair. It hands received frames over with a one-cycle push strobe. A frame is a 32-bit ID word, a 4-bit length code and eight data bytes. In the ID word, bit 31 marks an extended ID and bit 30 marks a remote request. The transmit control register reports how many frames are still unsent. Three sticky interrupt flags (transmit done, receive, receive overrun) are combined with enable bits into one interrupt line.

Top module: `can_mbx_fifo`

## Requirements
- R1: After reset, every control, status, window and interrupt register reads 0, except that receive control reads 0x80 (empty flag set). tx_valid_o and irq_o are low.
- R2: The transmit window registers read back what was written: ID at 0x0, length code at 0x1 (only bits 3:0 kept), data bytes 0-3 at 0x2 and data bytes 4-7 at 0x3. Byte 0 sits in bits 7:0.
- R3: When the transmit queue is enabled (bit 0 of 0x8), a write of 0xFF to 0x9 stores the window contents as a new frame and raises the unsent count in bits 3:1 of 0x8 by one. Any other value written to 0x9 is ignored. Frames leave in commit order on tx_id_o/tx_dlc_o/tx_data_o while tx_valid_o is high.
- R4: A commit while four frames are unsent is ignored.
- R5: tx_done_i while tx_valid_o is high removes the oldest frame, lowers the count, and sets interrupt status bit 3 (address 0xC).
- R6: A frame with ID bit 30 set stores all data bytes as zero, whether it comes from the transmit window or from a receive push.
- R7: When the receive queue is enabled (bit 0 of 0xA) and not full, rx_push_i stores a frame and sets status bit 4. The oldest frame is shown at 0x4-0x7 and bit 7 of 0xA is clear while the queue holds any frame. The receive window reads 0 when the queue is empty.
- R8: A write of 0xFF to 0xB releases the shown frame. The write is ignored for other values or when the receive queue is empty.
- R9: A push into a full receive queue drops the frame and sets status bit 5.
- R10: Writing 0 to a status bit clears it and writing 1 leaves it. An event in the same cycle as a clearing write keeps the bit set.
- R11: irq_o is high exactly when some status bit 3, 4 or 5 is set with the same bit set in the enable register 0xD.
- R12: While a queue's enable bit is clear, that queue is held empty and its pointers are reset. Commits, pushes, releases and tx_done_i have no effect, and tx_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Combined interrupt |
| tx_valid_o | output | 1 | A committed transmit frame is waiting |
| tx_id_o | output | 32 | ID word of the oldest transmit frame |
| tx_dlc_o | output | 4 | Length code of the oldest transmit frame |
| tx_data_o | output | 64 | Data bytes of the oldest transmit frame, byte 0 in bits 7:0 |
| tx_done_i | input | 1 | Protocol side finished the oldest transmit frame |
| rx_push_i | input | 1 | Received frame strobe |
| rx_id_i | input | 32 | Received ID word |
| rx_dlc_i | input | 4 | Received length code |
| rx_data_i | input | 64 | Received data bytes |

## Verification
A read or write pointer that is off by one shows up within one frame: the window presents a different frame than the commit or push order predicts, so ID words that differ per frame expose it at the first read after an advance. A count that is wrong shows in the unsent field of 0x8 or the empty flag of 0xA right after the event. Because a count error also changes when the full and empty guards fire, the overflow drop and the empty-release cases show it again a few writes later. Flag logic faults show in the status register and irq_o in the cycle after the causing event.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DLC_W  = 4;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned ID_RTR = 30;

  typedef struct packed {
    logic [31:0]       id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } frame_t;

  typedef enum logic [ADDR_W-1:0] {
    A_TX_ID  = 4'h0, A_TX_DLC = 4'h1, A_TX_DL  = 4'h2, A_TX_DH  = 4'h3,
    A_RX_ID  = 4'h4, A_RX_DLC = 4'h5, A_RX_DL  = 4'h6, A_RX_DH  = 4'h7,
    A_TX_CTL = 4'h8, A_TX_ADV = 4'h9, A_RX_CTL = 4'hA, A_RX_ADV = 4'hB,
    A_ISR    = 4'hC, A_IER    = 4'hD
  } reg_addr_e;

  localparam logic [7:0] ADV_KEY = 8'hFF;
  localparam int unsigned F_TX   = 3;
  localparam int unsigned F_RX   = 4;
  localparam int unsigned F_OVR  = 5;
  localparam logic [7:0] F_MASK  = 8'b0011_1000;
endpackage

// File: rtl/can_frame_queue.sv
module can_frame_queue
  import can_mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  frame_t           din_i,
  input  logic             pop_i,
  output frame_t           head_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  frame_t           mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem[wr_q] <= din_i;
  end

  assign head_o = mem[rd_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/can_mbx_irq.sv
module can_mbx_irq
  import can_mbx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       isr_we_i,
  input  logic       ier_we_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] evt_i,
  output logic [7:0] isr_o,
  output logic [7:0] ier_o,
  output logic       irq_o
);
  logic [7:0] isr_q, ier_q, isr_d;

  // clearing write first, then events win
  always_comb begin
    isr_d = isr_q;
    if (isr_we_i) isr_d = isr_d & wdata_i;
    isr_d = (isr_d | evt_i) & F_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      ier_q <= '0;
    end else begin
      isr_q <= isr_d;
      if (ier_we_i) ier_q <= wdata_i & F_MASK;
    end
  end

  assign isr_o = isr_q;
  assign ier_o = ier_q;
  assign irq_o = |(isr_q & ier_q);
endmodule

// File: rtl/can_mbx_fifo.sv
module can_mbx_fifo
  import can_mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              tx_valid_o,
  output logic [31:0]       tx_id_o,
  output logic [DLC_W-1:0]  tx_dlc_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_done_i,
  input  logic              rx_push_i,
  input  logic [31:0]       rx_id_i,
  input  logic [DLC_W-1:0]  rx_dlc_i,
  input  logic [DATA_W-1:0] rx_data_i
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             tx_en_q, rx_en_q;
  frame_t           tx_win_q, tx_din, rx_din, tx_head, rx_head, rx_view;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_commit, tx_pop, rx_accept, rx_ovr, rx_rel;
  logic [7:0]       isr, ier, evt;
  logic             rx_empty;

  function automatic logic hit(input reg_addr_e a, input logic [ADDR_W-1:0] ad,
                               input logic we);
    return we && (ad == a);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      tx_win_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_TX_ID:  tx_win_q.id                <= reg_wdata_i;
        A_TX_DLC: tx_win_q.dlc               <= reg_wdata_i[DLC_W-1:0];
        A_TX_DL:  tx_win_q.data[31:0]        <= reg_wdata_i;
        A_TX_DH:  tx_win_q.data[63:32]       <= reg_wdata_i;
        A_TX_CTL: tx_en_q                    <= reg_wdata_i[0];
        A_RX_CTL: rx_en_q                    <= reg_wdata_i[0];
        default: ;
      endcase
    end
  end

  // remote requests carry no payload
  always_comb begin
    tx_din = tx_win_q;
    if (tx_win_q.id[ID_RTR]) tx_din.data = '0;
    rx_din = '{id: rx_id_i, dlc: rx_dlc_i, data: rx_data_i};
    if (rx_id_i[ID_RTR]) rx_din.data = '0;
  end

  assign tx_commit = hit(A_TX_ADV, reg_addr_i, reg_we_i) && reg_wdata_i[7:0] == ADV_KEY
                     && tx_en_q && tx_cnt != CNT_W'(DEPTH);
  assign tx_pop    = tx_done_i && tx_valid_o;
  assign rx_accept = rx_push_i && rx_en_q && rx_cnt != CNT_W'(DEPTH);
  assign rx_ovr    = rx_push_i && rx_en_q && rx_cnt == CNT_W'(DEPTH);
  assign rx_rel    = hit(A_RX_ADV, reg_addr_i, reg_we_i) && reg_wdata_i[7:0] == ADV_KEY
                     && rx_en_q && rx_cnt != '0;

  can_frame_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
    .clk_i, .rst_ni, .flush_i(!tx_en_q), .push_i(tx_commit), .din_i(tx_din),
    .pop_i(tx_pop), .head_o(tx_head), .cnt_o(tx_cnt)
  );

  can_frame_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
    .clk_i, .rst_ni, .flush_i(!rx_en_q), .push_i(rx_accept), .din_i(rx_din),
    .pop_i(rx_rel), .head_o(rx_head), .cnt_o(rx_cnt)
  );

  always_comb begin
    evt        = '0;
    evt[F_TX]  = tx_pop;
    evt[F_RX]  = rx_accept;
    evt[F_OVR] = rx_ovr;
  end

  can_mbx_irq u_irq (
    .clk_i, .rst_ni,
    .isr_we_i(hit(A_ISR, reg_addr_i, reg_we_i)),
    .ier_we_i(hit(A_IER, reg_addr_i, reg_we_i)),
    .wdata_i(reg_wdata_i[7:0]), .evt_i(evt),
    .isr_o(isr), .ier_o(ier), .irq_o(irq_o)
  );

  assign rx_empty   = !rx_en_q || rx_cnt == '0;
  assign rx_view    = rx_empty ? '0 : rx_head;
  assign tx_valid_o = tx_en_q && tx_cnt != '0;
  assign tx_id_o    = tx_head.id;
  assign tx_dlc_o   = tx_head.dlc;
  assign tx_data_o  = tx_head.data;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_TX_ID:  reg_rdata_o = tx_win_q.id;
      A_TX_DLC: reg_rdata_o = 32'(tx_win_q.dlc);
      A_TX_DL:  reg_rdata_o = tx_win_q.data[31:0];
      A_TX_DH:  reg_rdata_o = tx_win_q.data[63:32];
      A_RX_ID:  reg_rdata_o = rx_view.id;
      A_RX_DLC: reg_rdata_o = 32'(rx_view.dlc);
      A_RX_DL:  reg_rdata_o = rx_view.data[31:0];
      A_RX_DH:  reg_rdata_o = rx_view.data[63:32];
      A_TX_CTL: reg_rdata_o = {28'b0, tx_en_q ? 3'(tx_cnt) : 3'b0, tx_en_q};
      A_RX_CTL: reg_rdata_o = {24'b0, rx_empty, 6'b0, rx_en_q};
      A_ISR:    reg_rdata_o = {24'b0, isr};
      A_IER:    reg_rdata_o = {24'b0, ier};
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/can_mbx_fifo_chk.sv
module can_mbx_fifo_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_en_i,
  input logic             rx_en_i,
  input logic [CNT_W-1:0] tx_cnt_i,
  input logic [CNT_W-1:0] rx_cnt_i,
  input logic [7:0]       isr_i,
  input logic             tx_done_i,
  input logic             tx_valid_o,
  input logic             rx_push_i
);
  AST_TX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt_i <= CNT_W'(DEPTH)); // R4
  AST_RX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_i <= CNT_W'(DEPTH)); // R9
  AST_TX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> tx_cnt_i == '0); // R12
  AST_RX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> rx_cnt_i == '0); // R12
  AST_TX_DONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i && tx_valid_o |=> isr_i[3]); // R5
  AST_RX_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && rx_en_i && rx_cnt_i < CNT_W'(DEPTH) |=> isr_i[4] && rx_cnt_i != '0); // R7
  AST_RX_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && rx_en_i && rx_cnt_i == CNT_W'(DEPTH) |=> isr_i[5]); // R9
endmodule

bind can_mbx_fifo can_mbx_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_q), .rx_en_i(rx_en_q),
  .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .isr_i(isr), .tx_done_i(tx_done_i),
  .tx_valid_o(tx_valid_o), .rx_push_i(rx_push_i)
);

// File: tb/can_mbx_fifo_test.sv
module can_mbx_fifo_test;
  localparam logic [3:0] TXID = 4'h0, TXDLC = 4'h1, TXDL = 4'h2, TXDH = 4'h3;
  localparam logic [3:0] RXID = 4'h4, RXDLC = 4'h5, RXDL = 4'h6, RXDH = 4'h7;
  localparam logic [3:0] TXCTL = 4'h8, TXADV = 4'h9, RXCTL = 4'hA, RXADV = 4'hB;
  localparam logic [3:0] ISR = 4'hC, IER = 4'hD;

  typedef struct packed {
    logic        we;
    logic [3:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b0, TXCTL, 32'h0, 32'h0, 8'd1},          // R1
    '{1'b0, RXCTL, 32'h0, 32'h80, 8'd1},         // R1
    '{1'b0, ISR,   32'h0, 32'h0, 8'd1},          // R1
    '{1'b0, RXID,  32'h0, 32'h0, 8'd1},          // R1
    '{1'b1, TXID,  32'h8ABCDEF1, 32'h0, 8'd2},
    '{1'b0, TXID,  32'h0, 32'h8ABCDEF1, 8'd2},   // R2
    '{1'b1, TXDLC, 32'hFFFFFFF8, 32'h0, 8'd2},
    '{1'b0, TXDLC, 32'h0, 32'h8, 8'd2},          // R2
    '{1'b1, TXDL,  32'h11223344, 32'h0, 8'd2},
    '{1'b1, TXDH,  32'h55667788, 32'h0, 8'd2},
    '{1'b0, TXDH,  32'h0, 32'h55667788, 8'd2},   // R2
    '{1'b1, TXADV, 32'hFF, 32'h0, 8'd12},
    '{1'b0, TXCTL, 32'h0, 32'h0, 8'd12},         // R12 commit while disabled
    '{1'b1, TXCTL, 32'h1, 32'h0, 8'd3},
    '{1'b1, TXADV, 32'h12, 32'h0, 8'd3},
    '{1'b0, TXCTL, 32'h0, 32'h1, 8'd3},          // R3 wrong key ignored
    '{1'b1, TXADV, 32'hFF, 32'h0, 8'd3},
    '{1'b0, TXCTL, 32'h0, 32'h3, 8'd3},          // R3 count one
    '{1'b0, TXDL,  32'h0, 32'h11223344, 8'd2}    // R2
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, tx_valid_o, tx_done_i = 1'b0, rx_push_i = 1'b0;
  logic [31:0] tx_id_o, rx_id_i = '0;
  logic [3:0]  tx_dlc_o, rx_dlc_i = '0;
  logic [63:0] tx_data_o, rx_data_i = '0;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  can_mbx_fifo uut (.*);

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    check(req, 64'(reg_rdata_o), 64'(exp));
  endtask

  task automatic push(input logic [31:0] id, input logic [3:0] dlc, input logic [63:0] d);
    @(negedge clk_i);
    rx_push_i = 1'b1; rx_id_i = id; rx_dlc_i = dlc; rx_data_i = d;
    @(negedge clk_i);
    rx_push_i = 1'b0;
  endtask

  task automatic txdone();
    @(negedge clk_i);
    tx_done_i = 1'b1;
    @(negedge clk_i);
    tx_done_i = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1", {62'b0, tx_valid_o, irq_o}, 64'h0);
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].we) wr(TBL[i].a, TBL[i].d);
      else rd($sformatf("R%0d table %0d", TBL[i].req, i), TBL[i].a, TBL[i].exp);
    end

    // fill transmit queue: F2 remote, F3, F4
    wr(TXID, 32'h40000123); wr(TXADV, 32'hFF);
    wr(TXID, 32'h00400000); wr(TXADV, 32'hFF);
    wr(TXID, 32'h00800000); wr(TXADV, 32'hFF);
    rd("R3", TXCTL, 32'h9);
    wr(TXID, 32'h0FFFFFFF); wr(TXADV, 32'hFF);
    rd("R4", TXCTL, 32'h9);
    check("R3 valid", 64'(tx_valid_o), 64'h1);
    check("R3 head id", 64'(tx_id_o), 64'h8ABCDEF1);
    check("R3 head data", tx_data_o, 64'h55667788_11223344);
    check("R3 head dlc", 64'(tx_dlc_o), 64'h8);
    txdone();
    check("R6 tx remote id", 64'(tx_id_o), 64'h40000123);
    check("R6 tx remote data", tx_data_o, 64'h0);
    rd("R5", TXCTL, 32'h7);
    rd("R5", ISR, 32'h08);
    check("R11 masked", 64'(irq_o), 64'h0);
    txdone();
    check("R3 order", 64'(tx_id_o), 64'h00400000);
    check("R3 order data", tx_data_o, 64'h55667788_11223344);
    txdone(); txdone();
    check("R4 dropped commit", 64'(tx_valid_o), 64'h0);
    rd("R5", TXCTL, 32'h1);

    // interrupt flags
    wr(IER, 32'h08);
    check("R11 enabled", 64'(irq_o), 64'h1);
    wr(ISR, 32'hFFFFFFFF);
    rd("R10 write one", ISR, 32'h08);
    wr(ISR, 32'hF7);
    rd("R10 write zero", ISR, 32'h00);
    check("R11 cleared", 64'(irq_o), 64'h0);

    // disable flushes transmit queue
    wr(TXADV, 32'hFF);
    check("R12 pre", 64'(tx_valid_o), 64'h1);
    wr(TXCTL, 32'h0);
    check("R12 tx valid", 64'(tx_valid_o), 64'h0);
    txdone();
    rd("R12 no flag", ISR, 32'h00);
    wr(TXCTL, 32'h1);
    rd("R12 flushed", TXCTL, 32'h1);
    check("R12 tx empty", 64'(tx_valid_o), 64'h0);

    // receive
    push(32'h00000999, 4'h1, 64'h5);
    wr(RXCTL, 32'h1);
    rd("R12 rx dropped", RXCTL, 32'h81);
    rd("R12 rx flag", ISR, 32'h00);
    push(32'h00040000, 4'h3, 64'h0000000000CCBBAA);
    push(32'h40080000, 4'h2, 64'hDEAD);
    rd("R7", RXCTL, 32'h01);
    rd("R7", RXID, 32'h00040000);
    rd("R7", RXDLC, 32'h3);
    rd("R7", RXDL, 32'h00CCBBAA);
    rd("R7", ISR, 32'h10);
    wr(RXADV, 32'h33);
    rd("R8 wrong key", RXID, 32'h00040000);
    wr(RXADV, 32'hFF);
    rd("R8", RXID, 32'h40080000);
    rd("R6 rx remote", RXDL, 32'h0);
    push(32'h1, 4'h1, 64'h1); push(32'h2, 4'h1, 64'h1); push(32'h3, 4'h1, 64'h1);
    push(32'h99, 4'h1, 64'h1);
    rd("R9", ISR, 32'h30);
    wr(RXADV, 32'hFF); rd("R9", RXID, 32'h1);
    wr(RXADV, 32'hFF); rd("R9", RXID, 32'h2);
    wr(RXADV, 32'hFF); rd("R9", RXID, 32'h3);
    wr(RXADV, 32'hFF);
    rd("R8 empty", RXCTL, 32'h81);
    rd("R7 empty window", RXID, 32'h0);
    wr(RXADV, 32'hFF);
    push(32'h77, 4'h2, 64'h0);
    rd("R8 empty release ignored", RXID, 32'h77);
    rd("R8", RXCTL, 32'h01);

    // same-cycle event beats clearing write
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = ISR; reg_wdata_i = 32'h0;
    rx_push_i = 1'b1; rx_id_i = 32'h55;
    @(negedge clk_i);
    reg_we_i = 1'b0; rx_push_i = 1'b0;
    rd("R10 set wins", ISR, 32'h10);
    wr(IER, 32'h10);
    check("R11 rx", 64'(irq_o), 64'h1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule